// File: doc/BRIEF.md
# Audio Codec Register-Access Controller

This block is the CPU-facing register front end of an AC97-style audio interface. Software uses it to stage a codec register access and to configure one playback and one capture DMA channel. The bus side is a simple word-wide port. A request is qualified by `req_valid_i`, and `req_write_i` selects a write. The address is a byte address and is decoded to a word slot. Read data is a combinational function of the presented address.

Writing the codec control slot with its request bit set starts a codec transaction. The request bit is never stored, so it always reads back as zero. The direction bit picks which interrupt line fires. The set direction pulses the request line, and the clear direction pulses the reply line. Each pulse is one clock long. The low bit of each channel control slot drives that channel's enable output to the DMA engines. Serial link framing, data movement and the codec itself sit outside this block.

Top module: `codec_ctl_regs`

## Requirements
- R1: While reset is held low, and after it is released, every slot reads zero. Both enables and both interrupt outputs are low.
- R2: The word index is the byte address shifted right by 2. The slots, in index order 0 to 10, are: codec control, codec address, codec write data, codec read data, playback control, playback address, playback count, reserved, capture control, capture address, capture count. A full write to a stored slot other than index 0 reads back unchanged from the next cycle.
- R3: A write is accepted only when all four byte enables are set and address bits [1:0] are 00. Any other write changes no slot, no enable and no interrupt. A read at a misaligned address returns zero.
- R4: A write to codec control stores the written word with bit 0 forced to 0. The other bits read back as written.
- R5: An accepted codec-control write with bit 0 = 1 and bit 1 = 1 drives `irq_req_o` high for exactly the one cycle after the write. `irq_rep_o` stays low.
- R6: An accepted codec-control write with bit 0 = 1 and bit 1 = 0 drives `irq_rep_o` high for exactly the one cycle after the write. `irq_req_o` stays low.
- R7: Neither interrupt pulses unless an accepted codec-control write had bit 0 = 1 in the previous cycle. Back-to-back request writes give one pulse per write.
- R8: `play_en_o` equals bit 0 of playback control (index 4). It changes in the cycle after an accepted write to that slot and holds otherwise.
- R9: `cap_en_o` equals bit 0 of capture control (index 8). It changes in the cycle after an accepted write to that slot and holds otherwise.
- R10: The reserved index 7, and every index above 10, read as zero. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request qualifier |
| req_write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address |
| be_i | input | DATA_W/8 (4) | Byte enables, all must be set for a write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| irq_req_o | output | 1 | One-cycle pulse: codec write request started |
| irq_rep_o | output | 1 | One-cycle pulse: codec read request started |
| play_en_o | output | 1 | Playback DMA channel enable |
| cap_en_o | output | 1 | Capture DMA channel enable |

## Verification
The assertions assume that the bus inputs carry known values in every clocked cycle out of reset. They also assume that `addr_i` is stable whenever `rdata_o` is sampled, because the read path has no strobe. The bench changes every input only on the falling clock edge, never leaves an input undriven, and compares read data a step after that edge. Partial byte enables, misaligned addresses and unqualified writes are deliberately mixed in, so the checks for ignored writes see real stimulus.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int unsigned NUM_SLOTS = 11;

  typedef enum logic [3:0] {
    SL_CODEC_CTL   = 4'd0,
    SL_CODEC_ADDR  = 4'd1,
    SL_CODEC_WDATA = 4'd2,
    SL_CODEC_RDATA = 4'd3,
    SL_PLAY_CTL    = 4'd4,
    SL_PLAY_ADDR   = 4'd5,
    SL_PLAY_LEFT   = 4'd6,
    SL_RSVD        = 4'd7,
    SL_CAP_CTL     = 4'd8,
    SL_CAP_ADDR    = 4'd9,
    SL_CAP_LEFT    = 4'd10
  } slot_e;

  localparam int unsigned REQ_BIT   = 0;
  localparam int unsigned DIR_BIT   = 1;
  localparam int unsigned CH_EN_BIT = 0;

  // slots that own storage; the reserved hole has none
  localparam logic [NUM_SLOTS-1:0] SLOT_STORED = 11'b111_0111_1111;
endpackage

// File: rtl/codec_ctl_addr_dec.sv
module codec_ctl_addr_dec
  import codec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BE_W   = 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BE_W-1:0]      be_i,
  output logic [NUM_SLOTS-1:0] slot_sel_o,
  output logic                 full_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign full_o  = &be_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    if (SLOT_STORED[s]) begin : g_map
      assign slot_sel_o[s] = aligned && (widx == WIDX_W'(s));
    end else begin : g_hole
      assign slot_sel_o[s] = 1'b0;
    end
  end
endmodule

// File: rtl/codec_ctl_reg_bank.sv
module codec_ctl_reg_bank
  import codec_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] wr_sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_SLOTS-1:0] rd_sel_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 play_en_o,
  output logic                 cap_en_o
);
  logic [DATA_W-1:0] slot_val [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (SLOT_STORED[g]) begin : g_store
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] wr_val;

      if (g == int'(SL_CODEC_CTL)) begin : g_selfclr
        assign wr_val = wdata_i & ~(DATA_W'(1) << REQ_BIT);
      end else begin : g_plain
        assign wr_val = wdata_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= '0;
        else if (wr_sel_i[g]) q <= wr_val;
      end

      assign slot_val[g] = q;
    end else begin : g_hole
      assign slot_val[g] = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_sel_i[i]) rdata_o = rdata_o | slot_val[i];
    end
  end

  assign play_en_o = slot_val[int'(SL_PLAY_CTL)][CH_EN_BIT];
  assign cap_en_o  = slot_val[int'(SL_CAP_CTL)][CH_EN_BIT];
endmodule

// File: rtl/codec_ctl_irq_gen.sv
module codec_ctl_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic req_bit_i,
  input  logic dir_bit_i,
  output logic irq_req_o,
  output logic irq_rep_o
);
  logic start;
  assign start = ctl_wr_i && req_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o <= 1'b0;
      irq_rep_o <= 1'b0;
    end else begin
      irq_req_o <= start && dir_bit_i;
      irq_rep_o <= start && !dir_bit_i;
    end
  end
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_req_o,
  output logic                irq_rep_o,
  output logic                play_en_o,
  output logic                cap_en_o
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic [NUM_SLOTS-1:0] slot_sel;
  logic [NUM_SLOTS-1:0] wr_sel;
  logic                 full;
  logic                 wr_go;

  codec_ctl_addr_dec #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .addr_i     (addr_i),
    .be_i       (be_i),
    .slot_sel_o (slot_sel),
    .full_o     (full)
  );

  assign wr_go  = req_valid_i && req_write_i && full;
  assign wr_sel = slot_sel & {NUM_SLOTS{wr_go}};

  codec_ctl_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_sel_i  (wr_sel),
    .wdata_i   (wdata_i),
    .rd_sel_i  (slot_sel),
    .rdata_o   (rdata_o),
    .play_en_o (play_en_o),
    .cap_en_o  (cap_en_o)
  );

  codec_ctl_irq_gen u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_wr_i  (wr_sel[int'(SL_CODEC_CTL)]),
    .req_bit_i (wdata_i[REQ_BIT]),
    .dir_bit_i (wdata_i[DIR_BIT]),
    .irq_req_o (irq_req_o),
    .irq_rep_o (irq_rep_o)
  );
endmodule

// File: rtl/codec_ctl_regs_chk.sv
module codec_ctl_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W/8-1:0] be_i,
  input logic [1:0]          wdata_lo_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                irq_req_o,
  input logic                irq_rep_o,
  input logic                play_en_o,
  input logic                cap_en_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic aligned, wr_full, ctl_hit, play_hit, cap_hit;

  assign widx     = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign wr_full  = req_valid_i && req_write_i && (&be_i) && aligned;
  assign ctl_hit  = wr_full && (widx == WIDX_W'(0));
  assign play_hit = wr_full && (widx == WIDX_W'(4));
  assign cap_hit  = wr_full && (widx == WIDX_W'(8));

  assert_req_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_hit && wdata_lo_i == 2'b11) |=> (irq_req_o && !irq_rep_o));

  assert_rep_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_hit && wdata_lo_i == 2'b01) |=> (irq_rep_o && !irq_req_o));

  assert_no_spurious_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_hit && wdata_lo_i[0]) |=> (!irq_req_o && !irq_rep_o));

  assert_req_bit_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(0)) |-> !rdata_o[0]);

  assert_misaligned_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned |-> (rdata_o == '0));

  assert_hole_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && (widx == WIDX_W'(7) || widx > WIDX_W'(10))) |-> (rdata_o == '0));

  assert_play_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_hit |=> (play_en_o == $past(wdata_lo_i[0])));

  assert_play_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_hit |=> $stable(play_en_o));

  assert_cap_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (cap_en_o == $past(wdata_lo_i[0])));

  assert_cap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_hit |=> $stable(cap_en_o));
endmodule

bind codec_ctl_regs codec_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .addr_i      (addr_i),
  .be_i        (be_i),
  .wdata_lo_i  (wdata_i[1:0]),
  .rdata_o     (rdata_o),
  .irq_req_o   (irq_req_o),
  .irq_rep_o   (irq_rep_o),
  .play_en_o   (play_en_o),
  .cap_en_o    (cap_en_o)
);

// File: tb/codec_ctl_regs_bench.sv
`timescale 1ns/1ps
module codec_ctl_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_req_o, irq_rep_o, play_en_o, cap_en_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [11];

  always #4 clk_i = ~clk_i;

  codec_ctl_regs u_codec_ctl_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_req_o(irq_req_o),
    .irq_rep_o(irq_rep_o), .play_en_o(play_en_o), .cap_en_o(cap_en_o)
  );

  function automatic bit mapped(input logic [7:0] a);
    int idx = int'(a >> 2);
    return (a[1:0] == 2'b00) && idx <= 10 && idx != 7;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    return mapped(a) ? mdl[int'(a >> 2)] : 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // one bus cycle: drive on falling edge, compare read, then compare after the rising edge
  task automatic bus(input bit v, input bit w, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] d, input string tag);
    bit exp_req = 0, exp_rep = 0;
    @(negedge clk_i);
    req_valid_i = v; req_write_i = w; addr_i = a; be_i = be; wdata_i = d;
    #1;
    chk(rdata_o, mdl_read(a), {tag, " rdata"});
    if (v && w && be == 4'hF && mapped(a)) begin
      if (a == 8'h00) begin
        exp_req = d[0] && d[1];
        exp_rep = d[0] && !d[1];
        mdl[0] = d & ~32'h1;
      end else begin
        mdl[int'(a >> 2)] = d;
      end
    end
    @(posedge clk_i);
    #1;
    chk({31'b0, irq_req_o}, {31'b0, exp_req}, {tag, " irq_req"});
    chk({31'b0, irq_rep_o}, {31'b0, exp_rep}, {tag, " irq_rep"});
    chk({31'b0, play_en_o}, {31'b0, mdl[4][0]}, {tag, " play_en"});
    chk({31'b0, cap_en_o},  {31'b0, mdl[8][0]}, {tag, " cap_en"});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    bus(1, 1, a, 4'hF, d, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus(1, 0, a, 4'hF, 32'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_valid_i = 0; req_write_i = 0;
    for (int i = 0; i < 11; i++) mdl[i] = '0;
    #1;
    chk({30'b0, play_en_o, cap_en_o}, 32'h0, "R1 enables in reset");
    chk({30'b0, irq_req_o, irq_rep_o}, 32'h0, "R1 irqs in reset");
    chk(rdata_o, 32'h0, "R1 rdata in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1: all words read zero after reset
    for (int i = 0; i < 16; i++) bus(0, 0, 8'(i * 4), 4'h0, 32'h0, "R1 post-reset");

    // R2: store and read back plain slots
    wr(8'h04, 32'h1234_5678, "R2 codec addr");
    wr(8'h08, 32'hDEAD_BEEF, "R2 codec wdata");
    wr(8'h0C, 32'hFFFF_FFFF, "R2 codec rdata");
    wr(8'h14, 32'h0000_8000, "R2 play addr");
    wr(8'h18, 32'h0000_0400, "R2 play left");
    wr(8'h24, 32'h0001_0000, "R2 cap addr");
    wr(8'h28, 32'h5555_AAAA, "R2 cap left");
    for (int i = 0; i < 11; i++) rd(8'(i * 4), "R2 readback");

    // R5/R4: write-direction request
    wr(8'h00, 32'h0000_0003, "R5 req write");
    rd(8'h00, "R4 selfclear");
    // R6: read-direction request
    wr(8'h00, 32'hA5A5_0001, "R6 req read");
    rd(8'h00, "R4 upper bits kept");
    // R7: no request bit, then back-to-back requests
    wr(8'h00, 32'hFFFF_FFFE, "R7 no req");
    wr(8'h00, 32'h0000_0003, "R7 back2back a");
    wr(8'h00, 32'h0000_0001, "R7 back2back b");
    wr(8'h00, 32'h0000_0003, "R7 back2back c");
    bus(0, 0, 8'h00, 4'h0, 32'h0, "R7 idle after pulse");

    // R8/R9: channel enables
    wr(8'h10, 32'h0000_0001, "R8 play on");
    wr(8'h20, 32'hF0F0_0001, "R9 cap on");
    wr(8'h10, 32'hFFFF_FFFE, "R8 play off");
    rd(8'h10, "R8 play ctl readback");
    wr(8'h20, 32'h0000_0000, "R9 cap off");
    wr(8'h20, 32'h0000_0001, "R9 cap on again");

    // R3: partial, misaligned and unqualified writes
    bus(1, 1, 8'h04, 4'h7, 32'h0BAD_0BAD, "R3 partial be");
    bus(1, 1, 8'h05, 4'hF, 32'h0BAD_0BAD, "R3 misaligned");
    bus(1, 1, 8'h01, 4'hF, 32'h0000_0003, "R3 misaligned ctl");
    bus(1, 1, 8'h12, 4'hF, 32'h0000_0001, "R3 misaligned play");
    bus(1, 1, 8'h20, 4'hE, 32'h0000_0000, "R3 partial cap");
    bus(0, 1, 8'h00, 4'hF, 32'h0000_0003, "R3 unqualified ctl");
    bus(1, 0, 8'h00, 4'hF, 32'h0000_0003, "R3 read not write");
    rd(8'h05, "R3 misaligned read");
    rd(8'h04, "R3 readback after partial");

    // R10: reserved and out-of-range words
    wr(8'h1C, 32'hCAFE_F00D, "R10 reserved write");
    rd(8'h1C, "R10 reserved read");
    wr(8'h2C, 32'h1111_1111, "R10 idx 11");
    wr(8'hFC, 32'h2222_2222, "R10 idx 63");
    rd(8'h2C, "R10 idx 11 read");
    rd(8'hFC, "R10 idx 63 read");

    // R1: reset mid-run clears everything
    do_reset();
    for (int i = 0; i < 11; i++) rd(8'(i * 4), "R1 second reset");

    summary();
    $finish;
  end
endmodule